// File: doc/BRIEF.md
# CAN Frame Error Detector

This block watches the bit stream of one CAN node, one bit time at a time, and reports protocol violations. A frame sequencer elsewhere in the node supplies a strobe at each sample point, the level the node is driving, the level it sampled on the bus, and markers that say which part of the frame the current bit belongs to. The detector runs five independent checks: CRC, stuffing, bit, form and acknowledgement. More than one of them can fire on the same bit. Each check sets its own sticky flag. When an error needs an error frame, the block raises a request that the sequencer acts on at the following bit.

A listen-only mode supports automatic bit-rate search. In this mode the node's bus output is forced recessive, so it neither transmits nor acknowledges. The error flags keep updating, error-frame requests are withheld, and a freeze output tells the fault-confinement counters to hold. Bus levels use 1 for recessive and 0 for dominant.

Top module: `can_err_detect`

## Requirements
- R1: After reset all five error flags and `err_frame_req` are 0.
- R2: The CRC register starts at zero and steps with polynomial 0x4599 (15 bits). It is fed every strobed bit marked by `fld_crc_cov` unless `stuff_bit` is set. Non-stuff bits marked by `fld_crc_seq` are collected MSB first as the received CRC. At the strobe of the `fld_crc_del` bit, a mismatch between the two sets `err_crc`. The register is cleared at any strobed bit that carries neither coverage marker.
- R3: A sixth consecutive strobed bit of the same sampled level while `fld_stuff` is high sets `err_stuff`. A change of level restarts the run at one. A strobed bit outside the region ends the run.
- R4: When `listen_only` is 0 and the node is driving, meaning `role_tx` is 1 or `tx_lvl` is dominant, a strobed bit whose `rx_lvl` differs from `tx_lvl` sets `err_bit`.
- R5: Sending recessive and sampling dominant does not set `err_bit` during `fld_arb` or `fld_ack_slot`. Sending dominant and sampling recessive there still does.
- R6: A dominant sample in a bit marked `fld_crc_del`, `fld_ack_del` or `fld_eof` sets `err_form`.
- R7: A recessive sample in the `fld_ack_slot` bit while `role_tx` is 1 sets `err_ack`.
- R8: A strobe that detects a stuff, bit, form or acknowledgement error raises `err_frame_req` on the next clock. The request holds until the clock at the next strobe, where it drops unless that bit raises a new error.
- R9: A CRC mismatch found at the CRC delimiter raises `err_frame_req` at the strobe of the following `fld_ack_del` bit, with the same one-clock timing as R8.
- R10: While `listen_only` is 1, `bus_drive` is 1 whatever `tx_lvl` is, and `freeze_cnt` is 1. No new error-frame request is raised and no bit error is checked. The other flags still update.
- R11: Flags are visible one clock after the detecting strobe and stay set until `clr_flags` is pulsed. A detection in the same cycle as `clr_flags` wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe at each bit sample point |
| tx_lvl | input | 1 | Level the node intends to drive (1 recessive) |
| rx_lvl | input | 1 | Sampled bus level (1 recessive) |
| fld_arb | input | 1 | Bit is in the arbitration field |
| fld_stuff | input | 1 | Bit is in the stuffing region |
| fld_crc_cov | input | 1 | Bit is covered by the CRC (start of frame through data) |
| fld_crc_seq | input | 1 | Bit is in the received CRC sequence |
| stuff_bit | input | 1 | Bit is a stuff bit (excluded from CRC) |
| fld_crc_del | input | 1 | Bit is the CRC delimiter |
| fld_ack_slot | input | 1 | Bit is the acknowledgement slot |
| fld_ack_del | input | 1 | Bit is the acknowledgement delimiter |
| fld_eof | input | 1 | Bit is in end of frame |
| role_tx | input | 1 | Node is the transmitter of this frame |
| listen_only | input | 1 | Listen-only bit-rate search mode |
| clr_flags | input | 1 | One-cycle clear of all error flags |
| bus_drive | output | 1 | Level actually driven onto the bus |
| err_crc | output | 1 | Sticky CRC error flag |
| err_stuff | output | 1 | Sticky stuffing error flag |
| err_bit | output | 1 | Sticky bit error flag |
| err_form | output | 1 | Sticky form error flag |
| err_ack | output | 1 | Sticky acknowledgement error flag |
| err_frame_req | output | 1 | Request for an error frame starting at the next bit |
| freeze_cnt | output | 1 | Hold the error counters |

## Verification
Faults differ in how soon they show at the ports. A corrupted run counter in the stuffing monitor shows up within six bits, either as a spurious `err_stuff` or as a missing one. A wrong CRC register stays hidden until that frame's CRC delimiter, where `err_crc` appears. The request then appears at the acknowledgement delimiter. Random frames with correct and corrupted CRCs, missing acknowledgements and dominant end-of-frame bits are played in both roles, so that every frame ends in a known flag pattern. Directed bit sequences pin down the boundary cases: the run length of exactly five or six bits, arbitration masking, and the clock on which the request rises and falls.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    localparam int unsigned CAN_CRC_W = 15;
    localparam logic [CAN_CRC_W-1:0] CAN_CRC_POLY = 15'h4599;

    typedef struct packed {
        logic crc;
        logic stf;
        logic bite;
        logic frm;
        logic ack;
    } err_flags_t;

endpackage

// File: rtl/can_crc_chk.sv
module can_crc_chk #(
    parameter int unsigned        CRC_W    = 15,
    parameter logic [CRC_W-1:0]   CRC_POLY = 15'h4599
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_lvl,
    input  logic stuff_bit,
    input  logic fld_crc_cov,
    input  logic fld_crc_seq,
    input  logic fld_crc_del,
    output logic crc_mismatch
);

    typedef struct packed {
        logic [CRC_W-1:0] calc;
        logic [CRC_W-1:0] rcv;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic    fb;
    logic [CRC_W-1:0] stepped;

    always_comb begin
        st_d    = st_q;
        fb      = st_q.calc[CRC_W-1] ^ rx_lvl;
        stepped = {st_q.calc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        crc_mismatch = bit_stb && fld_crc_del && (st_q.calc != st_q.rcv);

        if (bit_stb) begin
            if (!fld_crc_cov && !fld_crc_seq) begin
                st_d.calc = '0;
                st_d.rcv  = '0;
            end else if (!stuff_bit) begin
                if (fld_crc_cov) begin
                    st_d.calc = stepped;
                end
                if (fld_crc_seq) begin
                    st_d.rcv = {st_q.rcv[CRC_W-2:0], rx_lvl};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_stuff_mon.sv
module can_stuff_mon #(
    parameter int unsigned RUN_MAX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_lvl,
    input  logic fld_stuff,
    output logic stuff_viol
);

    localparam int unsigned LIMIT = RUN_MAX + 1;
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          last;
    } stf_st_t;

    stf_st_t       st_d, st_q;
    logic [CW-1:0] run_nx;

    always_comb begin
        st_d   = st_q;
        run_nx = '0;
        if (fld_stuff) begin
            if ((st_q.run != '0) && (rx_lvl == st_q.last)) begin
                run_nx = (st_q.run == CW'(LIMIT)) ? st_q.run : st_q.run + 1'b1;
            end else begin
                run_nx = CW'(1);
            end
        end
        stuff_viol = bit_stb && fld_stuff && (run_nx == CW'(LIMIT)) && (st_q.run != CW'(LIMIT));
        if (bit_stb) begin
            st_d.run  = run_nx;
            st_d.last = rx_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_field_chk.sv
module can_field_chk (
    input  logic bit_stb,
    input  logic tx_lvl,
    input  logic rx_lvl,
    input  logic fld_arb,
    input  logic fld_crc_del,
    input  logic fld_ack_slot,
    input  logic fld_ack_del,
    input  logic fld_eof,
    input  logic role_tx,
    input  logic listen_only,
    output logic bit_viol,
    output logic form_viol,
    output logic ack_viol
);

    logic driving;
    logic masked;

    always_comb begin
        driving   = !listen_only && (role_tx || !tx_lvl);
        masked    = tx_lvl && !rx_lvl && (fld_arb || fld_ack_slot);
        bit_viol  = bit_stb && driving && (tx_lvl != rx_lvl) && !masked;
        form_viol = bit_stb && !rx_lvl && (fld_crc_del || fld_ack_del || fld_eof);
        ack_viol  = bit_stb && fld_ack_slot && role_tx && rx_lvl;
    end

endmodule

// File: rtl/can_err_detect.sv
module can_err_detect
    import can_err_pkg::*;
#(
    parameter int unsigned STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_lvl,
    input  logic rx_lvl,
    input  logic fld_arb,
    input  logic fld_stuff,
    input  logic fld_crc_cov,
    input  logic fld_crc_seq,
    input  logic stuff_bit,
    input  logic fld_crc_del,
    input  logic fld_ack_slot,
    input  logic fld_ack_del,
    input  logic fld_eof,
    input  logic role_tx,
    input  logic listen_only,
    input  logic clr_flags,
    output logic bus_drive,
    output logic err_crc,
    output logic err_stuff,
    output logic err_bit,
    output logic err_form,
    output logic err_ack,
    output logic err_frame_req,
    output logic freeze_cnt
);

    typedef struct packed {
        err_flags_t flg;
        logic       req;
        logic       crc_pend;
    } top_st_t;

    top_st_t    st_d, st_q;
    err_flags_t hits;
    logic       crc_p, stf_p, bit_p, frm_p, ack_p;
    logic       crc_due;
    logic       want_req;

    can_crc_chk #(
        .CRC_W   (CAN_CRC_W),
        .CRC_POLY(CAN_CRC_POLY)
    ) u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .rx_lvl      (rx_lvl),
        .stuff_bit   (stuff_bit),
        .fld_crc_cov (fld_crc_cov),
        .fld_crc_seq (fld_crc_seq),
        .fld_crc_del (fld_crc_del),
        .crc_mismatch(crc_p)
    );

    can_stuff_mon #(
        .RUN_MAX(STUFF_RUN)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .rx_lvl    (rx_lvl),
        .fld_stuff (fld_stuff),
        .stuff_viol(stf_p)
    );

    can_field_chk u_field (
        .bit_stb     (bit_stb),
        .tx_lvl      (tx_lvl),
        .rx_lvl      (rx_lvl),
        .fld_arb     (fld_arb),
        .fld_crc_del (fld_crc_del),
        .fld_ack_slot(fld_ack_slot),
        .fld_ack_del (fld_ack_del),
        .fld_eof     (fld_eof),
        .role_tx     (role_tx),
        .listen_only (listen_only),
        .bit_viol    (bit_p),
        .form_viol   (frm_p),
        .ack_viol    (ack_p)
    );

    always_comb begin
        st_d = st_q;

        hits.crc  = crc_p;
        hits.stf  = stf_p;
        hits.bite = bit_p;
        hits.frm  = frm_p;
        hits.ack  = ack_p;

        // Sticky flags: a detection outranks a simultaneous clear.
        st_d.flg = (clr_flags ? '0 : st_q.flg) | hits;

        // A CRC mismatch waits for the acknowledgement delimiter.
        crc_due       = bit_stb && fld_ack_del && st_q.crc_pend;
        st_d.crc_pend = crc_p || (st_q.crc_pend && !(bit_stb && fld_ack_del));

        want_req = stf_p || bit_p || frm_p || ack_p || crc_due;
        if (want_req && !listen_only) begin
            st_d.req = 1'b1;
        end else if (bit_stb) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_drive     = listen_only ? 1'b1 : tx_lvl;
    assign freeze_cnt    = listen_only;
    assign err_crc       = st_q.flg.crc;
    assign err_stuff     = st_q.flg.stf;
    assign err_bit       = st_q.flg.bite;
    assign err_form      = st_q.flg.frm;
    assign err_ack       = st_q.flg.ack;
    assign err_frame_req = st_q.req;

endmodule

// File: rtl/can_err_detect_chk.sv
module can_err_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic tx_lvl,
    input logic rx_lvl,
    input logic fld_ack_slot,
    input logic fld_eof,
    input logic role_tx,
    input logic listen_only,
    input logic clr_flags,
    input logic bus_drive,
    input logic err_crc,
    input logic err_stuff,
    input logic err_bit,
    input logic err_form,
    input logic err_ack,
    input logic err_frame_req,
    input logic freeze_cnt
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !clr_flags) |=> $stable({err_crc, err_stuff, err_bit, err_form, err_ack}));

    p_form_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && fld_eof && !rx_lvl) |=> err_form);

    p_ack_missing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && fld_ack_slot && role_tx && rx_lvl) |=> err_ack);

    p_req_after_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && fld_eof && !rx_lvl && !listen_only) |=> err_frame_req);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame_req && !bit_stb) |=> err_frame_req);

    p_listen_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (listen_only && !err_frame_req) |=> !err_frame_req);

    p_listen_recessive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        listen_only |-> (bus_drive && freeze_cnt));

    p_driven_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !listen_only |-> (bus_drive == tx_lvl));

    p_sticky_crc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc && !clr_flags) |=> err_crc);

    p_sticky_stuff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stuff && !clr_flags) |=> err_stuff);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !bit_stb) |=> !(err_crc || err_stuff || err_bit || err_form || err_ack));

endmodule

bind can_err_detect can_err_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_stb      (bit_stb),
    .tx_lvl       (tx_lvl),
    .rx_lvl       (rx_lvl),
    .fld_ack_slot (fld_ack_slot),
    .fld_eof      (fld_eof),
    .role_tx      (role_tx),
    .listen_only  (listen_only),
    .clr_flags    (clr_flags),
    .bus_drive    (bus_drive),
    .err_crc      (err_crc),
    .err_stuff    (err_stuff),
    .err_bit      (err_bit),
    .err_form     (err_form),
    .err_ack      (err_ack),
    .err_frame_req(err_frame_req),
    .freeze_cnt   (freeze_cnt)
);

// File: tb/tb_can_err_detect.sv
`timescale 1ns/1ps
module tb_can_err_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, tx_lvl = 1'b1, rx_lvl = 1'b1;
    logic fld_arb = 0, fld_stuff = 0, fld_crc_cov = 0, fld_crc_seq = 0, stuff_bit = 0;
    logic fld_crc_del = 0, fld_ack_slot = 0, fld_ack_del = 0, fld_eof = 0;
    logic role_tx = 0, listen_only = 0, clr_flags = 0;
    logic bus_drive, err_crc, err_stuff, err_bit, err_form, err_ack, err_frame_req, freeze_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int st_run  = 0;
    logic st_last = 1'b1;
    logic saw_req = 1'b0;
    logic [31:0] seed_val;

    // Marker vector: {arb, stuff, cov, seq, sbit, cdel, aslot, adel, eof}
    localparam logic [8:0] M_ARB  = 9'b100000000;
    localparam logic [8:0] M_STF  = 9'b010000000;
    localparam logic [8:0] M_COV  = 9'b001000000;
    localparam logic [8:0] M_SEQ  = 9'b000100000;
    localparam logic [8:0] M_SB   = 9'b000010000;
    localparam logic [8:0] M_CDEL = 9'b000001000;
    localparam logic [8:0] M_ASL  = 9'b000000100;
    localparam logic [8:0] M_ADEL = 9'b000000010;
    localparam logic [8:0] M_EOF  = 9'b000000001;

    always #5 clk = ~clk;

    can_err_detect dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .fld_arb(fld_arb), .fld_stuff(fld_stuff), .fld_crc_cov(fld_crc_cov),
        .fld_crc_seq(fld_crc_seq), .stuff_bit(stuff_bit), .fld_crc_del(fld_crc_del),
        .fld_ack_slot(fld_ack_slot), .fld_ack_del(fld_ack_del), .fld_eof(fld_eof),
        .role_tx(role_tx), .listen_only(listen_only), .clr_flags(clr_flags),
        .bus_drive(bus_drive), .err_crc(err_crc), .err_stuff(err_stuff), .err_bit(err_bit),
        .err_form(err_form), .err_ack(err_ack), .err_frame_req(err_frame_req),
        .freeze_cnt(freeze_cnt)
    );

    function automatic logic [14:0] ref_crc(input logic [14:0] c, input logic b);
        logic [15:0] w;
        w = {c, 1'b0};
        if (c[14] ^ b) w = w ^ 16'hC599;
        return w[14:0];
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [4:0] flags();
        return {err_crc, err_stuff, err_bit, err_form, err_ack};
    endfunction

    task automatic dbit(input logic t, input logic r, input logic [8:0] m);
        @(negedge clk);
        tx_lvl = t; rx_lvl = r; bit_stb = 1'b1;
        {fld_arb, fld_stuff, fld_crc_cov, fld_crc_seq, stuff_bit,
         fld_crc_del, fld_ack_slot, fld_ack_del, fld_eof} = m;
        @(negedge clk);
        bit_stb = 1'b0;
        {fld_arb, fld_stuff, fld_crc_cov, fld_crc_seq, stuff_bit,
         fld_crc_del, fld_ack_slot, fld_ack_del, fld_eof} = '0;
        if (err_frame_req) saw_req = 1'b1;
    endtask

    task automatic clear();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        saw_req = 1'b0;
    endtask

    task automatic send_stf(input logic b, input logic [8:0] m, input logic as_tx);
        dbit(as_tx ? b : 1'b1, b, m);
        if (st_run > 0 && b == st_last) st_run++;
        else st_run = 1;
        st_last = b;
        if (st_run == 5) begin
            dbit(as_tx ? ~b : 1'b1, ~b, m | M_SB);
            st_last = ~b;
            st_run  = 1;
        end
    endtask

    task automatic run_frame(input logic as_tx, input int nbits, input logic crc_bad,
                             input logic ack_rec, input logic eof_dom, input logic lo);
        logic [14:0] c;
        logic [14:0] seq;
        logic b;
        logic [4:0] exp_f;
        c = '0;
        st_run = 0;
        role_tx = as_tx;
        listen_only = lo;
        saw_req = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            b = (i == 0) ? 1'b0 : 1'($urandom % 2);
            c = ref_crc(c, b);
            send_stf(b, M_STF | M_COV | ((i < 12) ? M_ARB : 9'b0), as_tx);
        end
        seq = c ^ (crc_bad ? (15'd1 << ($urandom % 15)) : 15'd0);
        for (int k = 14; k >= 0; k--) begin
            send_stf(seq[k], M_STF | M_SEQ, as_tx);
        end
        dbit(1'b1, 1'b1, M_CDEL);
        if (as_tx) dbit(1'b1, ack_rec, M_ASL);
        else       dbit(1'b0, 1'b0, M_ASL);
        dbit(1'b1, 1'b1, M_ADEL);
        for (int k = 0; k < 7; k++) begin
            dbit(1'b1, (eof_dom && k == 3) ? 1'b0 : 1'b1, M_EOF);
        end
        exp_f = {crc_bad, 1'b0, eof_dom & as_tx & ~lo, eof_dom, as_tx & ack_rec};
        check("R2/R4/R6/R7 frame flags", 32'(flags()), 32'(exp_f));
        check("R9/R10 request seen in frame", 32'(saw_req),
              32'(~lo & (crc_bad | eof_dom | (as_tx & ack_rec))));
        clear();
        check("R11 flags cleared", 32'(flags()), 32'd0);
        listen_only = 1'b0;
        role_tx = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", 32'(flags()), 32'd0);
        check("R1 request after reset", 32'(err_frame_req), 32'd0);

        // R3: five equal bits pass, sixth flags
        for (int i = 0; i < 5; i++) dbit(1'b1, 1'b0, M_STF);
        check("R3 five equal bits allowed", 32'(err_stuff), 32'd0);
        dbit(1'b1, 1'b0, M_STF);
        check("R3 sixth equal bit", 32'(err_stuff), 32'd1);
        check("R8 request after stuff error", 32'(err_frame_req), 32'd1);
        dbit(1'b1, 1'b1, 9'b0);
        check("R8 request drops at next strobe", 32'(err_frame_req), 32'd0);
        clear();
        // R3: level change restarts the run
        for (int i = 0; i < 5; i++) dbit(1'b1, 1'b0, M_STF);
        dbit(1'b1, 1'b1, M_STF);
        for (int i = 0; i < 5; i++) dbit(1'b1, 1'b0, M_STF);
        check("R3 run restarts on level change", 32'(err_stuff), 32'd0);
        // R3: leaving the region ends the run
        dbit(1'b1, 1'b0, 9'b0);
        for (int i = 0; i < 5; i++) dbit(1'b1, 1'b0, M_STF);
        check("R3 run ends outside region", 32'(err_stuff), 32'd0);
        dbit(1'b1, 1'b1, 9'b0);

        // R4/R8: bit error timing as transmitter
        role_tx = 1'b1;
        dbit(1'b1, 1'b0, 9'b0);
        check("R4 recessive sent dominant seen", 32'(err_bit), 32'd1);
        check("R8 request raised", 32'(err_frame_req), 32'd1);
        repeat (3) @(negedge clk);
        check("R8 request held between strobes", 32'(err_frame_req), 32'd1);
        dbit(1'b1, 1'b1, 9'b0);
        check("R8 request cleared at next strobe", 32'(err_frame_req), 32'd0);
        clear();

        // R5: masking in arbitration and ACK slot
        dbit(1'b1, 1'b0, M_ARB);
        check("R5 arbitration loss not a bit error", 32'(err_bit), 32'd0);
        dbit(1'b1, 1'b0, M_ASL);
        check("R5 ack slot not a bit error", 32'(flags()), 32'd0);
        dbit(1'b0, 1'b1, M_ARB);
        check("R5 dominant lost in arbitration", 32'(err_bit), 32'd1);
        clear();
        role_tx = 1'b0;
        dbit(1'b0, 1'b1, 9'b0);
        check("R4 receiver driving dominant", 32'(err_bit), 32'd1);
        clear();
        dbit(1'b1, 1'b0, 9'b0);
        check("R4 idle receiver not checked", 32'(err_bit), 32'd0);

        // R6: each fixed field
        dbit(1'b1, 1'b0, M_CDEL);
        check("R6 dominant CRC delimiter", 32'(err_form), 32'd1);
        clear();
        dbit(1'b1, 1'b0, M_ADEL);
        check("R6 dominant ACK delimiter", 32'(err_form), 32'd1);
        clear();

        // R10: listen-only
        listen_only = 1'b1;
        role_tx = 1'b1;
        @(negedge clk);
        tx_lvl = 1'b0;
        #1;
        check("R10 bus forced recessive", 32'(bus_drive), 32'd1);
        check("R10 counters frozen", 32'(freeze_cnt), 32'd1);
        dbit(1'b0, 1'b1, 9'b0);
        check("R10 no bit check", 32'(err_bit), 32'd0);
        dbit(1'b1, 1'b0, M_EOF);
        check("R10 form flag still updates", 32'(err_form), 32'd1);
        check("R10 no request", 32'(err_frame_req), 32'd0);
        listen_only = 1'b0;
        role_tx = 1'b0;
        clear();
        @(negedge clk);
        tx_lvl = 1'b0;
        #1;
        check("R10 normal drive follows tx", 32'(bus_drive), 32'd0);
        check("R10 freeze released", 32'(freeze_cnt), 32'd0);

        // R11: set beats clear in the same cycle
        @(negedge clk);
        tx_lvl = 1'b1; rx_lvl = 1'b0; fld_eof = 1'b1; bit_stb = 1'b1; clr_flags = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; fld_eof = 1'b0; clr_flags = 1'b0;
        check("R11 detection wins over clear", 32'(err_form), 32'd1);
        clear();

        // R2/R9 directed frames
        run_frame(1'b0, 20, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 20, 1'b1, 1'b0, 1'b0, 1'b0);

        // Random mix
        for (int f = 0; f < 40; f++) begin
            logic as_tx, lo;
            as_tx = 1'($urandom % 2);
            lo    = as_tx ? 1'b0 : 1'(($urandom % 4) == 0);
            run_frame(as_tx, 19 + int'($urandom % 40), 1'(($urandom % 3) == 0),
                      1'(($urandom % 3) == 0), 1'(($urandom % 4) == 0), lo);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule